// File: doc/BRIEF.md
# Synchronous FIFO with Newest-Entry Replace

This block is a single-clock first-in first-out queue of configurable word width and depth. A producer pushes words with a write enable while the queue reports room through a writable flag. A consumer sees the oldest word and a readable flag, and acknowledges each word to remove it. A fill-level output gives the number of stored, unread words at all times.

A replace qualifier turns a write into an in-place overwrite of the most recently written word, so a producer can revise the newest queued value without growing the queue. The read side is built in one of two variants chosen by a parameter. In first-word-fall-through mode (the default) the oldest word is shown combinationally. In registered mode the acknowledged word is delivered from a register one cycle later, so the storage can be a synchronous-read RAM.

Top module: `replace_fifo`

## Requirements
- R1: After reset the fill level is 0, readable is low and writable is high.
- R2: Writable is high exactly when the fill level is below DEPTH. A plain write (replace low) while writable is low is ignored: the level stays at DEPTH and the stored words are unchanged.
- R3: Readable is high exactly when the fill level is above 0. A read acknowledge while readable is low is ignored and the level stays 0.
- R4: In first-word-fall-through mode (REG_OUT = 0), the oldest stored word is driven on the read data while readable is high, with no acknowledge needed. After an acknowledge, the next word is shown from the following cycle.
- R5: The fill level rises by one for each accepted append and falls by one for each accepted read. An append and a read in the same cycle on a queue that is neither empty nor full leave the level unchanged.
- R6: Write enable with replace high on a non-empty queue overwrites the newest stored word with the input data and leaves the level unchanged. This also applies when the queue is full.
- R7: Write enable with replace high on an empty queue acts as an ordinary append, so the level becomes 1 and the word is readable.
- R8: Replace high with write enable low changes nothing.
- R9: The read and write positions wrap modulo DEPTH. First-in first-out order holds across more than DEPTH writes.
- R10: In registered mode (REG_OUT = 1), the word removed by an accepted acknowledge appears on the read data in the cycle after the acknowledge and holds until the next accepted acknowledge. Read data is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | WIDTH | Word to append or to replace with |
| wr_en | input | 1 | Write request |
| wr_replace | input | 1 | With wr_en, overwrite the newest word instead of appending |
| wr_ready | output | 1 | Queue has room for an append |
| rd_data | output | WIDTH | Oldest word (fall-through) or last acknowledged word (registered) |
| rd_ack | input | 1 | Remove the oldest word |
| rd_valid | output | 1 | Queue is not empty |
| fill_level | output | $clog2(DEPTH)+1 | Number of unread words |

## Verification
The bench goes after the replace corner cases. An overwrite that lands on the write slot instead of the one behind it would make the revised value surface as an extra word. A replace counted as an append would push the level past its true value. A replace on an empty queue that is dropped would lose the word. It also drives appends into a full queue and acknowledges into an empty one, where a missing guard corrupts the level or the data order. It runs the write position around the ring twice, so a wrong wrap would scramble the read order. The registered variant is driven by the same stimulus, so a read register that loads without an acknowledge would show a changed value while idle.

// File: rtl/replace_fifo_pkg.sv
package replace_fifo_pkg;

    // Advance a ring position by one, wrapping at the depth.
    function automatic int unsigned ring_next(int unsigned pos, int unsigned depth);
        return (pos == depth - 1) ? 0 : pos + 1;
    endfunction

    // Step a ring position back by one, wrapping at zero.
    function automatic int unsigned ring_prev(int unsigned pos, int unsigned depth);
        return (pos == 0) ? depth - 1 : pos - 1;
    endfunction

endpackage

// File: rtl/replace_fifo_ctrl.sv
module replace_fifo_ctrl
    import replace_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_replace,
    input  logic          rd_ack,
    output logic          wr_ready,
    output logic          rd_valid,
    output logic [LW-1:0] level,
    output logic          mem_we,
    output logic [PW-1:0] mem_waddr,
    output logic [PW-1:0] rd_ptr,
    output logic          pop
);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [LW-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        not_full, not_empty, push, overwrite;

    always_comb begin
        not_full  = (st_q.cnt != LW'(DEPTH));
        not_empty = (st_q.cnt != '0);
        overwrite = wr_en && wr_replace && not_empty;
        push      = wr_en && !overwrite && not_full;
        pop       = rd_ack && not_empty;

        st_d = st_q;
        if (push)
            st_d.wptr = PW'(ring_next(int'(st_q.wptr), DEPTH));
        if (pop)
            st_d.rptr = PW'(ring_next(int'(st_q.rptr), DEPTH));
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        mem_we    = push || overwrite;
        mem_waddr = overwrite ? PW'(ring_prev(int'(st_q.wptr), DEPTH)) : st_q.wptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_ready = not_full;
    assign rd_valid = not_empty;
    assign level    = st_q.cnt;
    assign rd_ptr   = st_q.rptr;

    // R2: a plain append into a full queue leaves it full
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && wr_en && !wr_replace && !rd_ack) |=> (level == LW'(DEPTH)));

    // R3: an acknowledge on an empty queue leaves it empty
    p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_ack && !wr_en) |=> (level == '0));

    // R5: append and read together in the middle keep the level
    p_both_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_replace && rd_ack && level != '0 && level != LW'(DEPTH)) |=> $stable(level));

    // R5: level never exceeds the depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R6: an overwrite of the newest word keeps the level
    p_replace_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_replace && level != '0 && !rd_ack) |=> $stable(level));

    // R8: replace without write enable and without read keeps the level
    p_replace_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && wr_replace && !rd_ack) |=> $stable(level));

endmodule

// File: rtl/replace_fifo_store.sv
module replace_fifo_store #(
    parameter int WIDTH   = 8,
    parameter int DEPTH   = 8,
    parameter bit REG_OUT = 1'b0,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    input  logic             re,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [WIDTH-1:0] out_d, out_q;

            always_comb begin
                out_d = out_q;
                if (re)
                    out_d = mem_q[raddr];
            end

            always_ff @(posedge clk) begin
                if (!rst_n)
                    out_q <= '0;
                else
                    out_q <= out_d;
            end

            assign rdata = out_q;

            // R10: the output register moves only on an accepted acknowledge
            p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !re |=> $stable(rdata));
        end else begin : g_fwft
            assign rdata = mem_q[raddr];
        end
    endgenerate

endmodule

// File: rtl/replace_fifo.sv
module replace_fifo #(
    parameter int WIDTH   = 8,
    parameter int DEPTH   = 8,
    parameter bit REG_OUT = 1'b0,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = PW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en,
    input  logic             wr_replace,
    output logic             wr_ready,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_ack,
    output logic             rd_valid,
    output logic [LW-1:0]    fill_level
);

    logic          mem_we, pop;
    logic [PW-1:0] mem_waddr, rd_ptr;

    replace_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_replace(wr_replace),
        .rd_ack    (rd_ack),
        .wr_ready  (wr_ready),
        .rd_valid  (rd_valid),
        .level     (fill_level),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .rd_ptr    (rd_ptr),
        .pop       (pop)
    );

    replace_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .REG_OUT(REG_OUT)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(wr_data),
        .raddr(rd_ptr),
        .re   (pop),
        .rdata(rd_data)
    );

    // R1: flags agree with the level at every sampled cycle
    p_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid == (fill_level != '0)) && (wr_ready == (fill_level != LW'(DEPTH))));

endmodule

// File: tb/tb_replace_fifo.sv
module tb_replace_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int D  = 4;
    localparam int LW = $clog2(D) + 1;
    localparam int NV = 19;

    // {wr_en, replace, rd_ack, wdata, level after, fwft head after, registered data after}
    localparam logic [30:0] VEC [NV] = '{
        {3'b100, 8'h11, 4'd1, 8'h11, 8'h00},  // append
        {3'b100, 8'h22, 4'd2, 8'h11, 8'h00},  // append
        {3'b110, 8'h33, 4'd2, 8'h11, 8'h00},  // R6 replace 22 -> 33
        {3'b001, 8'h00, 4'd1, 8'h33, 8'h11},  // R4 pop
        {3'b101, 8'h44, 4'd1, 8'h44, 8'h33},  // R5 append+pop
        {3'b100, 8'h55, 4'd2, 8'h44, 8'h33},
        {3'b100, 8'h66, 4'd3, 8'h44, 8'h33},
        {3'b100, 8'h77, 4'd4, 8'h44, 8'h33},  // full
        {3'b100, 8'h88, 4'd4, 8'h44, 8'h33},  // R2 ignored append
        {3'b110, 8'h99, 4'd4, 8'h44, 8'h33},  // R6 replace at full, 77 -> 99
        {3'b010, 8'hAA, 4'd4, 8'h44, 8'h33},  // R8 replace without write
        {3'b001, 8'h00, 4'd3, 8'h55, 8'h44},
        {3'b001, 8'h00, 4'd2, 8'h66, 8'h55},
        {3'b001, 8'h00, 4'd1, 8'h99, 8'h66},  // R6/R8 newest is 99
        {3'b001, 8'h00, 4'd0, 8'h00, 8'h99},
        {3'b001, 8'h00, 4'd0, 8'h00, 8'h99},  // R3 pop on empty ignored
        {3'b110, 8'hBB, 4'd1, 8'hBB, 8'h99},  // R7 replace on empty appends
        {3'b101, 8'hCC, 4'd1, 8'hCC, 8'hBB},  // R9 second wrap
        {3'b001, 8'h00, 4'd0, 8'h00, 8'hCC}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_en = 1'b0, wr_replace = 1'b0, rd_ack = 1'b0;
    logic          wr_ready, rd_valid, wr_ready_r, rd_valid_r;
    logic [W-1:0]  rd_data, rd_data_r;
    logic [LW-1:0] fill_level, fill_level_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    replace_fifo #(.WIDTH(W), .DEPTH(D), .REG_OUT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
        .wr_replace(wr_replace), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_ack(rd_ack), .rd_valid(rd_valid), .fill_level(fill_level)
    );

    replace_fifo #(.WIDTH(W), .DEPTH(D), .REG_OUT(1'b1)) dut_reg (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
        .wr_replace(wr_replace), .wr_ready(wr_ready_r), .rd_data(rd_data_r),
        .rd_ack(rd_ack), .rd_valid(rd_valid_r), .fill_level(fill_level_r)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic rep, input logic ack, input logic [W-1:0] d);
        wr_en = we; wr_replace = rep; rd_ack = ack; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_replace = 1'b0; rd_ack = 1'b0;
    endtask

    task automatic check_idle(input string tag, input int lvl);
        check({tag, " R5 level"}, 32'(fill_level), 32'(lvl));
        check({tag, " R3 readable"}, 32'(rd_valid), 32'(lvl > 0));
        check({tag, " R2 writable"}, 32'(wr_ready), 32'(lvl < D));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of both variants
        check("R1 level", 32'(fill_level), 0);
        check("R1 readable", 32'(rd_valid), 0);
        check("R1 writable", 32'(wr_ready), 1);
        check("R1 reg level", 32'(fill_level_r), 0);
        check("R1 reg data", 32'(rd_data_r), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            step(v[30], v[29], v[28], v[27:20]);
            check_idle($sformatf("vec%0d", i), int'(v[19:16]));
            if (v[19:16] != 0)
                check($sformatf("vec%0d R4 R9 head", i), 32'(rd_data), 32'(v[15:8]));
            check($sformatf("vec%0d R10 reg data", i), 32'(rd_data_r), 32'(v[7:0]));
            check($sformatf("vec%0d R10 reg level", i), 32'(fill_level_r), 32'(v[19:16]));
        end

        // R10: idle cycles leave the registered output unchanged
        step(1'b0, 1'b0, 1'b0, 8'h00);
        check("R10 idle hold", 32'(rd_data_r), 32'hCC);

        // R9: fill across the wrap point and drain in order
        for (int k = 0; k < D; k++) step(1'b1, 1'b0, 1'b0, W'(8'hD0 + k));
        check_idle("R9 filled", D);
        for (int k = 0; k < D; k++) begin
            check($sformatf("R9 order %0d", k), 32'(rd_data), 32'(8'hD0 + k));
            step(1'b0, 1'b0, 1'b1, 8'h00);
            check($sformatf("R10 order %0d", k), 32'(rd_data_r), 32'(8'hD0 + k));
        end
        check_idle("R9 drained", 0);

        // R1: reset while holding data returns to empty
        step(1'b1, 1'b0, 1'b0, 8'hE1);
        step(1'b1, 1'b0, 1'b0, 8'hE2);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset level", 32'(fill_level), 0);
        check("R1 mid reset readable", 32'(rd_valid), 0);
        check("R1 mid reset writable", 32'(wr_ready), 1);
        check("R1 mid reset reg data", 32'(rd_data_r), 0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule